// File: doc/BRIEF.md
# SPI Serial Clock and Chip-Select Timer

This block produces the serial clock (SCK) and the chip-select (CS) waveform for a SPI master that talks to a single slave. Every interval is counted in core clock cycles and programmed as a count minus one. The intervals are the CS setup before the first clock phase, the high and low halves of each SCK period, the CS hold after the last phase, and a minimum deasserted gap before the next frame. Clock polarity, clock phase and the CS active level are set by separate inputs.

A one-cycle start pulse begins a frame. A bit count gives the number of SCK periods, and each period has a leading and a trailing edge. Alongside SCK the block gives a datapath a shift strobe and a sample strobe. The sample strobe marks whichever edge the edge-select input picks, and it can be pushed later by a 3-bit tick delay. The shift strobe marks the other edge. A done pulse signals that the hold interval has ended. All configuration inputs must stay stable while a frame is in progress.

Top module: `spi_clk_cs_timer`

## Requirements
- R1: While reset is held low, CS sits at its inactive level and SCK equals `cpol`. `shift_stb`, `sample_stb` and `done` are all low.
- R2: A start sampled while the block is idle drives CS active from the next cycle on. SCK then stays at the `cpol` level for `setup_m1`+1 cycles before the first half-period begins.
- R3: Each SCK half-period lasts `high_m1`+1 cycles while SCK is high and `low_m1`+1 cycles while SCK is low. A field value of 0 is treated as 1, so every half lasts at least two cycles and the fastest SCK is the core clock divided by four.
- R4: A frame contains `nbits_m1`+1 SCK periods. SCK rests at `cpol`. With `cpha`=0 the first half of each period is at the rest level. With `cpha`=1 the first half is at the opposite level.
- R5: After the last period, SCK returns to `cpol` and CS stays active for `hold_m1`+1 more cycles.
- R6: After the hold interval, CS stays inactive for `gap_m1`+1 cycles before the next start is accepted. When start is held high, the inactive run between two frames is exactly `gap_m1`+2 cycles.
- R7: `cs_act_high`=1 makes CS active-high (active = 1). `cs_act_high`=0 makes it active-low (active = 0).
- R8: With `smp_trail`=0, `sample_stb` marks leading edges and `shift_stb` marks trailing edges. With `smp_trail`=1 the roles swap. Each strobe is a one-cycle pulse in the first cycle in which SCK shows the new level, so each frame has `nbits_m1`+1 pulses of each.
- R9: `sample_stb` is delayed by `tick_dly` cycles (0 to 7) relative to its edge, and no pulse is lost.
- R10: `done` pulses for exactly one cycle: the first cycle after the hold interval, which is the same cycle in which CS goes inactive.
- R11: A start that arrives while a frame or its inactive gap is in progress is ignored and does not change the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a frame (accepted when idle) |
| nbits_m1 | input | 8 | SCK periods in the frame, minus one |
| high_m1 | input | 16 | SCK high-half length, minus one |
| low_m1 | input | 16 | SCK low-half length, minus one |
| setup_m1 | input | 16 | CS setup length, minus one |
| hold_m1 | input | 16 | CS hold length, minus one |
| gap_m1 | input | 8 | Minimum CS inactive gap, minus one |
| cpol | input | 1 | SCK rest level |
| cpha | input | 1 | 1: first half of each period at the active level |
| cs_act_high | input | 1 | CS active level select |
| smp_trail | input | 1 | 1: sample on trailing edges, shift on leading edges |
| tick_dly | input | 3 | Extra cycles of delay on the sample strobe |
| sck | output | 1 | Serial clock |
| cs | output | 1 | Chip select |
| shift_stb | output | 1 | Shift-edge strobe for the datapath |
| sample_stb | output | 1 | Delayed sample-edge strobe for the datapath |
| done | output | 1 | One-cycle pulse at the end of the hold interval |

## Verification
Random frames mix all four clock modes with both CS levels and both edge selects. Short, unequal high and low counts show whether each half is timed by its own level's count rather than by its position in the period. Directed frames cover the all-zero fastest setting, which catches missing clamping, and the longest tick delay, which catches lost or misplaced delayed strobes. A start pulse injected mid-frame shows whether a busy frame can be restarted, and a start held high across two frames measures the exact inactive gap.

// File: rtl/spi_tmr_pkg.sv
package spi_tmr_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_FIRST,
        PH_SECOND,
        PH_HOLD,
        PH_GAP
    } phase_e;

endpackage

// File: rtl/spi_tmr_seq.sv
module spi_tmr_seq
    import spi_tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int GAP_W  = 8,
    parameter int BITS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BITS_W-1:0] nbits_m1,
    input  logic [CNT_W-1:0]  high_m1,
    input  logic [CNT_W-1:0]  low_m1,
    input  logic [CNT_W-1:0]  setup_m1,
    input  logic [CNT_W-1:0]  hold_m1,
    input  logic [GAP_W-1:0]  gap_m1,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              smp_trail,
    output logic              sck_rel,
    output logic              cs_on,
    output logic              shift_ev,
    output logic              samp_ev,
    output logic              done
);

    typedef struct packed {
        phase_e             ph;
        logic [CNT_W-1:0]   cnt;
        logic [BITS_W-1:0]  bits;
        logic               rel;
        logic               cs_on;
        logic               shift;
        logic               samp;
        logic               done;
    } seq_t;

    seq_t st_d, st_q;
    logic lead_ev, trail_ev;

    // half length for an absolute SCK level; zero fields are raised to one
    function automatic logic [CNT_W-1:0] half_len(input logic lvl,
                                                  input logic [CNT_W-1:0] hi,
                                                  input logic [CNT_W-1:0] lo);
        logic [CNT_W-1:0] v;
        v = lvl ? hi : lo;
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

    always_comb begin
        st_d       = st_q;
        st_d.shift = 1'b0;
        st_d.samp  = 1'b0;
        st_d.done  = 1'b0;
        lead_ev    = 1'b0;
        trail_ev   = 1'b0;
        case (st_q.ph)
            PH_IDLE: begin
                st_d.rel = 1'b0;
                if (start) begin
                    st_d.ph    = PH_SETUP;
                    st_d.cnt   = setup_m1;
                    st_d.cs_on = 1'b1;
                end
            end
            PH_SETUP: begin
                if (st_q.cnt == '0) begin
                    st_d.ph   = PH_FIRST;
                    st_d.bits = nbits_m1;
                    st_d.rel  = cpha;
                    st_d.cnt  = half_len(cpol ^ cpha, high_m1, low_m1);
                    lead_ev   = cpha;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
            PH_FIRST: begin
                if (st_q.cnt == '0) begin
                    st_d.ph  = PH_SECOND;
                    st_d.rel = ~cpha;
                    st_d.cnt = half_len(~(cpol ^ cpha), high_m1, low_m1);
                    lead_ev  = ~cpha;
                    trail_ev = cpha;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
            PH_SECOND: begin
                if (st_q.cnt == '0) begin
                    trail_ev = ~cpha;
                    if (st_q.bits == '0) begin
                        st_d.ph  = PH_HOLD;
                        st_d.rel = 1'b0;
                        st_d.cnt = hold_m1;
                    end else begin
                        st_d.ph   = PH_FIRST;
                        st_d.bits = st_q.bits - BITS_W'(1);
                        st_d.rel  = cpha;
                        st_d.cnt  = half_len(cpol ^ cpha, high_m1, low_m1);
                        lead_ev   = cpha;
                    end
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
            PH_HOLD: begin
                if (st_q.cnt == '0) begin
                    st_d.ph    = PH_GAP;
                    st_d.cnt   = CNT_W'(gap_m1);
                    st_d.cs_on = 1'b0;
                    st_d.done  = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
            PH_GAP: begin
                if (st_q.cnt == '0) st_d.ph = PH_IDLE;
                else                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
            default: st_d.ph = PH_IDLE;
        endcase
        st_d.samp  = smp_trail ? trail_ev : lead_ev;
        st_d.shift = smp_trail ? lead_ev  : trail_ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, cnt: '0, bits: '0, rel: 1'b0,
                      cs_on: 1'b0, shift: 1'b0, samp: 1'b0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sck_rel  = st_q.rel;
    assign cs_on    = st_q.cs_on;
    assign shift_ev = st_q.shift;
    assign samp_ev  = st_q.samp;
    assign done     = st_q.done;

    AST_REST_WHEN_CS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.cs_on |-> !st_q.rel); // R4
    AST_HALF_MIN_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rel != $past(st_q.rel)) |=> $stable(st_q.rel)); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done); // R10
    AST_DONE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> ($past(st_q.ph) == PH_HOLD) && !st_q.cs_on); // R10
    AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.shift && st_q.samp)); // R8
    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_GAP && start) |=> !st_q.cs_on); // R11

endmodule

// File: rtl/spi_tmr_dly.sv
module spi_tmr_dly #(
    parameter int DLY_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_in,
    input  logic [DLY_W-1:0] tick,
    output logic             stb
);

    localparam int DEPTH = (1 << DLY_W) - 1;

    logic [DEPTH-1:0] pipe_d, pipe_q;

    generate
        if (DEPTH > 1) begin : g_long
            always_comb pipe_d = {pipe_q[DEPTH-2:0], ev_in};
        end else begin : g_short
            always_comb pipe_d = ev_in;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    always_comb begin
        if (tick == '0) stb = ev_in;
        else            stb = pipe_q[tick - DLY_W'(1)];
    end

    AST_DLY_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (tick == DLY_W'(1) && $stable(tick) && ev_in) |=> stb); // R9
    AST_DLY_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick == '0) |-> (stb == ev_in)); // R9

endmodule

// File: rtl/spi_clk_cs_timer.sv
module spi_clk_cs_timer #(
    parameter int CNT_W  = 16,
    parameter int GAP_W  = 8,
    parameter int BITS_W = 8,
    parameter int DLY_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BITS_W-1:0] nbits_m1,
    input  logic [CNT_W-1:0]  high_m1,
    input  logic [CNT_W-1:0]  low_m1,
    input  logic [CNT_W-1:0]  setup_m1,
    input  logic [CNT_W-1:0]  hold_m1,
    input  logic [GAP_W-1:0]  gap_m1,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              cs_act_high,
    input  logic              smp_trail,
    input  logic [DLY_W-1:0]  tick_dly,
    output logic              sck,
    output logic              cs,
    output logic              shift_stb,
    output logic              sample_stb,
    output logic              done
);

    logic sck_rel, cs_on, samp_ev;

    spi_tmr_seq #(
        .CNT_W (CNT_W),
        .GAP_W (GAP_W),
        .BITS_W(BITS_W)
    ) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .nbits_m1 (nbits_m1),
        .high_m1  (high_m1),
        .low_m1   (low_m1),
        .setup_m1 (setup_m1),
        .hold_m1  (hold_m1),
        .gap_m1   (gap_m1),
        .cpol     (cpol),
        .cpha     (cpha),
        .smp_trail(smp_trail),
        .sck_rel  (sck_rel),
        .cs_on    (cs_on),
        .shift_ev (shift_stb),
        .samp_ev  (samp_ev),
        .done     (done)
    );

    spi_tmr_dly #(
        .DLY_W(DLY_W)
    ) i_dly (
        .clk  (clk),
        .rst_n(rst_n),
        .ev_in(samp_ev),
        .tick (tick_dly),
        .stb  (sample_stb)
    );

    assign sck = sck_rel ^ cpol;
    assign cs  = cs_on ? cs_act_high : ~cs_act_high;

    AST_CS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs == ~cs_act_high)); // R7

endmodule

// File: tb/test_spi_clk_cs_timer.sv
module test_spi_clk_cs_timer;

    localparam int NW = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  nbits_m1 = '0;
    logic [15:0] high_m1 = '0, low_m1 = '0, setup_m1 = '0, hold_m1 = '0;
    logic [7:0]  gap_m1 = '0;
    logic        cpol = 1'b0, cpha = 1'b0, cs_act_high = 1'b0, smp_trail = 1'b0;
    logic [2:0]  tick_dly = '0;
    logic        sck, cs, shift_stb, sample_stb, done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic e_cs [NW], e_sck [NW], e_sh [NW], e_sa [NW], e_dn [NW];
    logic a_cs [NW], a_sck [NW], a_sh [NW], a_sa [NW], a_dn [NW];

    spi_clk_cs_timer i_spi_clk_cs_timer (
        .clk(clk), .rst_n(rst_n), .start(start), .nbits_m1(nbits_m1),
        .high_m1(high_m1), .low_m1(low_m1), .setup_m1(setup_m1),
        .hold_m1(hold_m1), .gap_m1(gap_m1), .cpol(cpol), .cpha(cpha),
        .cs_act_high(cs_act_high), .smp_trail(smp_trail), .tick_dly(tick_dly),
        .sck(sck), .cs(cs), .shift_stb(shift_stb), .sample_stb(sample_stb),
        .done(done)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic check(input string tag, input logic act, input logic expv);
        checks = checks + 1;
        if (act !== expv) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, expv);
        end
    endtask

    // mark an edge event at cycle t (lead=1 leading, 0 trailing)
    task automatic put_edge(input int t, input bit lead);
        if (lead ^ smp_trail) begin
            if (t + int'(tick_dly) < NW) e_sa[t + int'(tick_dly)] = 1'b1;
        end else begin
            e_sh[t] = 1'b1;
        end
    endtask

    // expected waveform from the requirements; index 0 = first cycle with CS active
    task automatic build_exp();
        int t;
        logic act, a_lvl;
        int la, lb;
        act   = cs_act_high;
        a_lvl = cpol ^ cpha;
        la = (a_lvl ? eff(int'(high_m1)) : eff(int'(low_m1))) + 1;
        lb = (a_lvl ? eff(int'(low_m1)) : eff(int'(high_m1))) + 1;
        for (int i = 0; i < NW; i++) begin
            e_cs[i] = ~act; e_sck[i] = cpol; e_sh[i] = 1'b0; e_sa[i] = 1'b0; e_dn[i] = 1'b0;
        end
        t = 0;
        for (int i = 0; i <= int'(setup_m1); i++) begin e_cs[t] = act; t++; end
        for (int k = 0; k <= int'(nbits_m1); k++) begin
            if (cpha) put_edge(t, 1'b1);
            else if (k > 0) put_edge(t, 1'b0);
            for (int i = 0; i < la; i++) begin e_cs[t] = act; e_sck[t] = a_lvl; t++; end
            put_edge(t, !cpha);
            for (int i = 0; i < lb; i++) begin e_cs[t] = act; e_sck[t] = ~a_lvl; t++; end
        end
        if (!cpha) put_edge(t, 1'b0);
        for (int i = 0; i <= int'(hold_m1); i++) begin e_cs[t] = act; t++; end
        e_dn[t] = 1'b1;
    endtask

    task automatic run_frame(input bit poke);
        build_exp();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int i = 0; i < NW; i++) begin
            a_cs[i] = cs; a_sck[i] = sck; a_sh[i] = shift_stb;
            a_sa[i] = sample_stb; a_dn[i] = done;
            if (poke && i == 5) start = 1'b1;
            else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    task automatic compare_sig(input string tag, input int which);
        int bad;
        logic av, ev;
        bad = -1;
        for (int i = 0; i < NW; i++) begin
            case (which)
                0: begin av = a_cs[i]; ev = e_cs[i]; end
                1: begin av = a_sck[i]; ev = e_sck[i]; end
                2: begin av = a_sh[i]; ev = e_sh[i]; end
                3: begin av = a_sa[i]; ev = e_sa[i]; end
                default: begin av = a_dn[i]; ev = e_dn[i]; end
            endcase
            if (bad < 0 && av !== ev) bad = i;
        end
        checks = checks + 1;
        if (bad >= 0) begin
            errors = errors + 1;
            case (which)
                0: begin av = a_cs[bad]; ev = e_cs[bad]; end
                1: begin av = a_sck[bad]; ev = e_sck[bad]; end
                2: begin av = a_sh[bad]; ev = e_sh[bad]; end
                3: begin av = a_sa[bad]; ev = e_sa[bad]; end
                default: begin av = a_dn[bad]; ev = e_dn[bad]; end
            endcase
            $display("FAIL %s at cycle %0d: actual=%0b expected=%0b", tag, bad, av, ev);
        end
    endtask

    task automatic check_frame(input bit poke);
        run_frame(poke);
        compare_sig(poke ? "R11 cs while busy" : "R2/R5/R6/R7 cs", 0);
        compare_sig("R3/R4 sck", 1);
        compare_sig("R8 shift", 2);
        compare_sig("R8/R9 sample", 3);
        compare_sig("R10 done", 4);
    endtask

    task automatic randomize_cfg();
        nbits_m1    = 8'($urandom_range(0, 7));
        high_m1     = 16'($urandom_range(0, 4));
        low_m1      = 16'($urandom_range(0, 4));
        setup_m1    = 16'($urandom_range(0, 5));
        hold_m1     = 16'($urandom_range(0, 5));
        gap_m1      = 8'($urandom_range(0, 5));
        cpol        = 1'($urandom_range(0, 1));
        cpha        = 1'($urandom_range(0, 1));
        cs_act_high = 1'($urandom_range(0, 1));
        smp_trail   = 1'($urandom_range(0, 1));
        tick_dly    = 3'($urandom_range(0, 7));
    endtask

    initial begin
        int run;
        void'($urandom(32'h5A17));
        // R1: reset state
        repeat (2) @(negedge clk);
        check("R1 cs inactive", cs, 1'b1);
        check("R1 sck rest", sck, 1'b0);
        check("R1 shift", shift_stb, 1'b0);
        check("R1 sample", sample_stb, 1'b0);
        check("R1 done", done, 1'b0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // fastest setting, all fields zero (R3 divide-by-four)
        check_frame(1'b0);
        // slow asymmetric halves, mode 3, active-high CS, trailing sample, long tick
        nbits_m1 = 8'd3; high_m1 = 16'd5; low_m1 = 16'd1; setup_m1 = 16'd2;
        hold_m1 = 16'd3; gap_m1 = 8'd2; cpol = 1'b1; cpha = 1'b1;
        cs_act_high = 1'b1; smp_trail = 1'b1; tick_dly = 3'd7;
        check_frame(1'b0);
        // start poked during the frame (R11)
        cpol = 1'b0; cpha = 1'b0; tick_dly = 3'd2;
        check_frame(1'b1);

        for (int n = 0; n < 24; n++) begin
            randomize_cfg();
            check_frame(n % 6 == 5);
        end

        // R6: start held high across two frames, measure the inactive run
        nbits_m1 = 8'd0; high_m1 = 16'd0; low_m1 = 16'd0; setup_m1 = 16'd0;
        hold_m1 = 16'd0; gap_m1 = 8'd3; cs_act_high = 1'b0;
        @(negedge clk) start = 1'b1;
        run = 0;
        for (int i = 0; i < 200 && cs !== 1'b0; i++) @(negedge clk);
        for (int i = 0; i < 200 && cs === 1'b0; i++) @(negedge clk);
        for (int i = 0; i < 200 && cs === 1'b1; i++) begin run++; @(negedge clk); end
        start = 1'b0;
        checks = checks + 1;
        if (run != int'(gap_m1) + 2) begin
            errors = errors + 1;
            $display("FAIL R6 back-to-back gap: actual=%0d expected=%0d", run, int'(gap_m1) + 2);
        end
        repeat (30) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule